// File: doc/BRIEF.md
# Eight-bit Flag-Producing ALU

This block is the arithmetic and logic unit of a small register-to-register CPU. Two 8-bit operands and a 4-bit operation code go in. The block returns the 8-bit result at once, without a clock. It also returns a write-back indication that tells the register file whether the result belongs in the destination register, and a per-flag update mask. It offers add with carry, subtract with borrow, compare, the three bitwise operations, rotate left and rotate right through the carry, set carry and clear carry.

A small flag holder sits inside the block. It keeps zero, carry, negative and overflow. On a clock edge where the sequencer asserts the flag-enable input, it loads only the flags named in the mask. The carry it holds is the carry-in for the arithmetic operations and the rotates.

Top module: `alu8_flagged`

## Requirements
- R1: Operation code 0 (add) gives result = a + b + carry mod 256. It sets carry to the carry out of bit 7, overflow on two's-complement signed overflow, and updates z, c, n and v.
- R2: Operation code 1 (subtract) gives result = a - b - carry mod 256. Carry becomes 1 exactly when the unsigned a is less than b + carry (a borrow). Overflow is set on signed overflow. It updates z, c, n and v.
- R3: Operation code 2 (compare) shows the same result and flags as subtract, but wb_o is 0. wb_o is 1 for codes 0, 1 and 3 to 7 and 0 for all other codes.
- R4: Codes 3 (AND), 4 (OR) and 5 (XOR) give the bitwise result and update only z. The c, n and v flags keep their values.
- R5: Code 6 (rotate left) gives {a[6:0], carry} and moves a[7] into carry. Code 7 (rotate right) gives {carry, a[7:1]} and moves a[0] into carry. Both update z and c only.
- R6: Code 8 sets carry to 1 and code 9 clears it. z, n and v are unchanged, and result_o equals a.
- R7: For every operation that updates them, n equals bit 7 of the result and z is 1 exactly when the 8-bit result is zero.
- R8: Flags change only at a rising clock edge where flag_en_i is 1. Each flag loads only if its bit of upd_o is set; upd_o bit 0 is z, bit 1 is c, bit 2 is n and bit 3 is v. Reset clears all four flags.
- R9: Codes 10 to 15 do nothing. upd_o is 0, wb_o is 0, result_o equals a, and the flags stay unchanged even with flag_en_i at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag holder |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | Destination operand (a) |
| opb_i | input | 8 | Source operand (b) |
| flag_en_i | input | 1 | Apply this operation's flags at the next edge |
| result_o | output | 8 | Combinational result |
| wb_o | output | 1 | Result should be written to the destination |
| upd_o | output | 4 | Flags this operation may change {v,n,c,z} |
| zf_o | output | 1 | Held zero flag |
| cf_o | output | 1 | Held carry flag |
| nf_o | output | 1 | Held negative flag |
| vf_o | output | 1 | Held overflow flag |

## Verification
result_o, wb_o and upd_o are due in the same cycle as the operands and operation code, and the carry-in they use is the carry held at that moment. The bench drives inputs on the falling edge and samples these outputs two nanoseconds later, before the next rising edge. The four held flags change one rising edge after a cycle with flag_en_i high, so the bench checks them on the following falling edge against a model that moves only the masked flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int NFLAG = 4;
    localparam int OPW   = 4;

    localparam logic [OPW-1:0] OP_ADD  = 4'd0;
    localparam logic [OPW-1:0] OP_SUB  = 4'd1;
    localparam logic [OPW-1:0] OP_CMP  = 4'd2;
    localparam logic [OPW-1:0] OP_AND  = 4'd3;
    localparam logic [OPW-1:0] OP_OR   = 4'd4;
    localparam logic [OPW-1:0] OP_XOR  = 4'd5;
    localparam logic [OPW-1:0] OP_ROL  = 4'd6;
    localparam logic [OPW-1:0] OP_ROR  = 4'd7;
    localparam logic [OPW-1:0] OP_SETC = 4'd8;
    localparam logic [OPW-1:0] OP_CLRC = 4'd9;

    // bit 0 = z, bit 1 = c, bit 2 = n, bit 3 = v
    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } flags_t;

    localparam flags_t MASK_NONE  = '{v: 1'b0, n: 1'b0, c: 1'b0, z: 1'b0};
    localparam flags_t MASK_ALL   = '{v: 1'b1, n: 1'b1, c: 1'b1, z: 1'b1};
    localparam flags_t MASK_Z     = '{v: 1'b0, n: 1'b0, c: 1'b0, z: 1'b1};
    localparam flags_t MASK_ZC    = '{v: 1'b0, n: 1'b0, c: 1'b1, z: 1'b1};
    localparam flags_t MASK_C     = '{v: 1'b0, n: 1'b0, c: 1'b1, z: 1'b0};

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   wide;

    always_comb begin
        // subtraction: a + ~b + (1 - borrow_in)
        b_eff  = sub_i ? ~b_i : b_i;
        c_eff  = sub_i ? ~cin_i : cin_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum_o  = wide[W-1:0];
        cout_o = sub_i ? ~wide[W] : wide[W];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           cin_i,
    output logic [W-1:0]   res_o,
    output logic           cout_o
);
    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_ROL: begin
                res_o  = {a_i[W-2:0], cin_i};
                cout_o = a_i[W-1];
            end
            OP_ROR: begin
                res_o  = {cin_i, a_i[W-1:1]};
                cout_o = a_i[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en_i,
    input  flags_t mask_i,
    input  flags_t new_i,
    output flags_t flags_o
);
    logic [NFLAG-1:0] flag_d;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] mask_v;
    logic [NFLAG-1:0] new_v;

    assign mask_v = mask_i;
    assign new_v  = new_i;

    for (genvar g = 0; g < NFLAG; g++) begin : g_bit
        always_comb begin
            flag_d[g] = (en_i && mask_v[g]) ? new_v[g] : flag_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPW-1:0]   op_i,
    input  logic [DW-1:0]    opa_i,
    input  logic [DW-1:0]    opb_i,
    input  logic             flag_en_i,
    output logic [DW-1:0]    result_o,
    output logic             wb_o,
    output logic [NFLAG-1:0] upd_o,
    output logic             zf_o,
    output logic             cf_o,
    output logic             nf_o,
    output logic             vf_o
);
    typedef struct packed {
        logic [DW-1:0] res;
        logic          wb;
        flags_t        mask;
        flags_t        newf;
    } alu_out_t;

    flags_t        flags_q;
    alu_out_t      out_d;
    logic [DW-1:0] as_sum;
    logic          as_cout;
    logic          as_ovf;
    logic          is_sub;
    logic [DW-1:0] bo_res;
    logic          bo_cout;

    assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);

    alu8_addsub #(.W(DW)) u_addsub (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (flags_q.c),
        .sub_i  (is_sub),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .ovf_o  (as_ovf)
    );

    alu8_bitops #(.W(DW)) u_bitops (
        .op_i   (op_i),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (flags_q.c),
        .res_o  (bo_res),
        .cout_o (bo_cout)
    );

    always_comb begin
        out_d      = '0;
        out_d.res  = opa_i;
        out_d.newf = flags_q;
        out_d.mask = MASK_NONE;
        out_d.wb   = 1'b0;
        unique case (op_i)
            OP_ADD, OP_SUB, OP_CMP: begin
                out_d.res    = as_sum;
                out_d.newf.c = as_cout;
                out_d.newf.v = as_ovf;
                out_d.mask   = MASK_ALL;
                out_d.wb     = (op_i != OP_CMP);
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res  = bo_res;
                out_d.mask = MASK_Z;
                out_d.wb   = 1'b1;
            end
            OP_ROL, OP_ROR: begin
                out_d.res    = bo_res;
                out_d.newf.c = bo_cout;
                out_d.mask   = MASK_ZC;
                out_d.wb     = 1'b1;
            end
            OP_SETC: begin
                out_d.newf.c = 1'b1;
                out_d.mask   = MASK_C;
            end
            OP_CLRC: begin
                out_d.newf.c = 1'b0;
                out_d.mask   = MASK_C;
            end
            default: ;
        endcase
        out_d.newf.z = (out_d.res == '0);
        out_d.newf.n = out_d.res[DW-1];
    end

    alu8_flagreg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (flag_en_i),
        .mask_i  (out_d.mask),
        .new_i   (out_d.newf),
        .flags_o (flags_q)
    );

    assign result_o = out_d.res;
    assign wb_o     = out_d.wb;
    assign upd_o    = out_d.mask;
    assign zf_o     = flags_q.z;
    assign cf_o     = flags_q.c;
    assign nf_o     = flags_q.n;
    assign vf_o     = flags_q.v;
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_i,
    input logic       flag_en_i,
    input logic [7:0] result_o,
    input logic       wb_o,
    input logic       zf_o,
    input logic       cf_o,
    input logic       nf_o,
    input logic       vf_o
);
    logic is_bitwise;
    logic is_result_op;
    assign is_bitwise   = (op_i == 4'd3) || (op_i == 4'd4) || (op_i == 4'd5);
    assign is_result_op = (op_i <= 4'd7);

    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |-> !wb_o); // R3
    AST_BITWISE_KEEPS_CNV: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && is_bitwise) |=> $stable({cf_o, nf_o, vf_o})); // R4
    AST_SETC_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i == 4'd8) |=> (cf_o && $stable({zf_o, nf_o, vf_o}))); // R6
    AST_CLRC_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i == 4'd9) |=> (!cf_o && $stable({zf_o, nf_o, vf_o}))); // R6
    AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && is_result_op) |=> (zf_o == ($past(result_o) == 8'h00))); // R7
    AST_NEG_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i <= 4'd2) |=> (nf_o == $past(result_o[7]))); // R7
    AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en_i |=> $stable({zf_o, cf_o, nf_o, vf_o})); // R8
    AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd10) |=> $stable({zf_o, cf_o, nf_o, vf_o})); // R9
endmodule

bind alu8_flagged alu8_flagged_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .flag_en_i (flag_en_i),
    .result_o  (result_o),
    .wb_o      (wb_o),
    .zf_o      (zf_o),
    .cf_o      (cf_o),
    .nf_o      (nf_o),
    .vf_o      (vf_o)
);

// File: tb/test_alu8_flagged.sv
`timescale 1ns/1ps
module test_alu8_flagged;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] opa_i = 8'd0;
    logic [7:0] opb_i = 8'd0;
    logic       flag_en_i = 1'b0;
    logic [7:0] result_o;
    logic       wb_o;
    logic [3:0] upd_o;
    logic       zf_o, cf_o, nf_o, vf_o;

    int total = 0;
    int bad = 0;
    logic [3:0] mflags = 4'b0000; // {v,n,c,z}

    always #10 clk = ~clk;

    alu8_flagged i_alu8_flagged (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .flag_en_i(flag_en_i), .result_o(result_o), .wb_o(wb_o), .upd_o(upd_o),
        .zf_o(zf_o), .cf_o(cf_o), .nf_o(nf_o), .vf_o(vf_o)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sgn(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    task automatic do_op(string req, logic [3:0] op, logic [7:0] a, logic [7:0] b, logic en);
        int c, s, ss, eres, ewb;
        logic [3:0] emask, nf;
        c = mflags[1];
        nf = mflags;
        eres = a; ewb = 0; emask = 4'b0000;
        case (op)
            4'd0: begin
                s = a + b + c; ss = sgn(a) + sgn(b) + c;
                eres = s % 256; ewb = 1; emask = 4'b1111;
                nf[1] = (s > 255); nf[3] = (ss > 127 || ss < -128);
            end
            4'd1, 4'd2: begin
                s = a - b - c; ss = sgn(a) - sgn(b) - c;
                eres = (s + 512) % 256; ewb = (op == 4'd1); emask = 4'b1111;
                nf[1] = (s < 0); nf[3] = (ss > 127 || ss < -128);
            end
            4'd3: begin eres = a & b; ewb = 1; emask = 4'b0001; end
            4'd4: begin eres = a | b; ewb = 1; emask = 4'b0001; end
            4'd5: begin eres = a ^ b; ewb = 1; emask = 4'b0001; end
            4'd6: begin eres = ((a * 2) % 256) + c; ewb = 1; emask = 4'b0011; nf[1] = a[7]; end
            4'd7: begin eres = (a / 2) + c * 128; ewb = 1; emask = 4'b0011; nf[1] = a[0]; end
            4'd8: begin emask = 4'b0010; nf[1] = 1'b1; end
            4'd9: begin emask = 4'b0010; nf[1] = 1'b0; end
            default: ;
        endcase
        nf[0] = (eres == 0);
        nf[2] = (eres >= 128);
        op_i = op; opa_i = a; opb_i = b; flag_en_i = en;
        #2;
        check(req, "result", result_o, eres);
        check(req, "wb", wb_o, ewb);
        check(req, "mask", upd_o, emask);
        @(posedge clk);
        @(negedge clk);
        if (en) mflags = (mflags & ~emask) | (nf & emask);
        check(req, "flags{v,n,c,z}", {vf_o, nf_o, cf_o, zf_o}, mflags);
        flag_en_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R8", "reset flags", {vf_o, nf_o, cf_o, zf_o}, 0);
    endtask

    task automatic t_add; // R1 R7
        do_op("R1", 4'd0, 8'h12, 8'h34, 1);
        do_op("R1", 4'd0, 8'hFF, 8'h01, 1); // zero and carry out
        do_op("R1", 4'd0, 8'h10, 8'h20, 1); // carry in adds one
        do_op("R1", 4'd0, 8'h7F, 8'h01, 1); // signed overflow
        do_op("R7", 4'd0, 8'h80, 8'h80, 1);
    endtask

    task automatic t_sub; // R2
        do_op("R2", 4'd9, 8'h00, 8'h00, 1);
        do_op("R2", 4'd1, 8'h00, 8'h01, 1); // borrow
        do_op("R2", 4'd1, 8'h05, 8'h05, 1); // borrow in makes it -1
        do_op("R2", 4'd1, 8'h80, 8'h01, 1); // signed overflow
        do_op("R2", 4'd1, 8'h50, 8'h20, 1);
    endtask

    task automatic t_cmp; // R3
        do_op("R3", 4'd9, 8'h00, 8'h00, 1);
        do_op("R3", 4'd2, 8'h42, 8'h42, 1);
        do_op("R3", 4'd2, 8'h10, 8'h20, 1);
    endtask

    task automatic t_logic; // R4
        do_op("R4", 4'd8, 8'h00, 8'h00, 1);
        do_op("R4", 4'd3, 8'hF0, 8'h0F, 1);
        do_op("R4", 4'd4, 8'hA0, 8'h05, 1);
        do_op("R4", 4'd5, 8'h5A, 8'h5A, 1);
    endtask

    task automatic t_rot; // R5
        do_op("R5", 4'd9, 8'h00, 8'h00, 1);
        do_op("R5", 4'd6, 8'h81, 8'h00, 1);
        do_op("R5", 4'd6, 8'h40, 8'h00, 1);
        do_op("R5", 4'd7, 8'h01, 8'h00, 1);
        do_op("R5", 4'd7, 8'h00, 8'h00, 1);
        do_op("R5", 4'd6, 8'h80, 8'h00, 1);
    endtask

    task automatic t_carry; // R6
        do_op("R6", 4'd0, 8'hFF, 8'h81, 1);
        do_op("R6", 4'd8, 8'h33, 8'h00, 1);
        do_op("R6", 4'd9, 8'h44, 8'h00, 1);
    endtask

    task automatic t_hold; // R8
        do_op("R8", 4'd1, 8'h00, 8'h05, 0);
        do_op("R8", 4'd8, 8'h00, 8'h00, 0);
    endtask

    task automatic t_unused; // R9
        do_op("R9", 4'd8, 8'h00, 8'h00, 1);
        for (int k = 10; k < 16; k++) do_op("R9", 4'(k), 8'h00, 8'hFF, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #5;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_rot();
        t_carry();
        t_hold();
        t_unused();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule